// File: doc/BRIEF.md
# Parity-Protected General-Purpose Port on an AHB-Lite Slave

The block is an AHB-Lite slave that controls a 16-bit general-purpose port. It holds two registers: a data word and a one-bit direction flag. The direction flag switches the whole port between input mode and output mode. In input mode, a read of the data register returns the word last sampled from the port pins. In output mode, the data register drives the port and a read returns the register's contents.

Both the incoming and the outgoing port words carry a seventeenth bit that holds parity. A run-time sense input picks the parity rule. Every cycle the block samples the input word and checks it against that rule. A registered error flag shows whether the sample failed the check.

Bus transfers follow the usual two-stage pipeline. Select, ready, transfer type, write and address are captured in the address phase. Write data is taken in the next cycle, and read data is presented in that same cycle. The slave never inserts wait states.

Top module: `parity_gpio_ahb`

## Requirements
- R1: A register access is started only when, at a clock edge, hsel_i=1, hready_i=1 and htrans_i is NONSEQ (2'b10) or SEQ (2'b11). If hsel_i=0, hready_i=0, or htrans_i is IDLE (2'b00) or BUSY (2'b01), no register changes and the following cycle returns hrdata_o=0.
- R2: A write whose address phase has haddr_i[7:0]=0x00 loads hwdata_i[15:0], taken in the cycle after the address phase, into the data register. In output mode, a read at 0x00 returns {16'h0, data register} in the cycle after its address phase.
- R3: A write at haddr_i[7:0]=0x04 loads hwdata_i[0] into the direction flag. A read at 0x04 returns {31'h0, direction flag}.
- R4: With the direction flag at 0 (input mode), port_out_o[15:0] is 0. A read at 0x00 returns {16'h0, port_in_i[15:0]} as sampled at the clock edge that ends the read's address phase.
- R5: With the direction flag at 1 (output mode), port_out_o[15:0] equals the data register.
- R6: port_out_o[16] always equals NOT(XOR of port_out_o[15:0] and par_sense_i). It follows par_sense_i within the same cycle.
- R7: After each clock edge, par_err_o is 1 exactly when the port_in_i[16] and par_sense_i sampled at that edge differ from NOT(XOR of port_in_i[15:0] and par_sense_i). The flag is not sticky.
- R8: Only haddr_i[7:0] is decoded. Writes to any low-byte offset other than 0x00 and 0x04 change neither register, and reads from such offsets return 0.
- R9: hreadyout_o is always 1, and hrdata_o[31:16] is always 0.
- R10: While rst_ni=0, and at once when it falls, the data register, the direction flag, any pending transfer and par_err_o are cleared. The port is then in input mode with port_out_o = {1'b1, 16'h0000} when par_sense_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hsel_i | input | 1 | Slave select |
| hready_i | input | 1 | Bus ready, qualifies the address phase |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | 1 = write, 0 = read |
| haddr_i | input | 32 | Byte address, low byte decoded |
| hwdata_i | input | 32 | Write data, data phase |
| port_in_i | input | 17 | Port input: bits 15:0 data, bit 16 parity |
| par_sense_i | input | 1 | Parity sense select |
| hreadyout_o | output | 1 | Transfer done, tied high |
| hrdata_o | output | 32 | Read data, data phase |
| port_out_o | output | 17 | Port output: bits 15:0 data, bit 16 generated parity |
| par_err_o | output | 1 | Registered input parity mismatch |

## Verification
The assertions assume that hwdata_i is valid in the cycle after a qualified write's address phase. They also assume that port_in_i and par_sense_i are stable around each sampling edge. The stimulus meets both assumptions by changing every input only on the falling clock edge.

The stimulus pipelines transfers back to back with random data-phase write data. It mixes mapped offsets, aliases above the decoded byte and unmapped offsets, and it sends non-qualifying select, ready and transfer-type combinations. Most input words carry correct parity, with a minority deliberately corrupted. The parity sense is flipped at random times, so both rules and both error outcomes occur in input mode and in output mode.

// File: rtl/gpar_pkg.sv
package gpar_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic     wr;
    logic     rd;
    reg_sel_e sel;
  } dphase_t;
endpackage

// File: rtl/gpar_parity.sv
module gpar_parity #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              sense_i,
  output logic              par_o
);
  assign par_o = ~^{data_i, sense_i};
endmodule

// File: rtl/gpar_addr_phase.sv
module gpar_addr_phase
  import gpar_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DEC_W    = 8,
  parameter logic [7:0]  DATA_OFS = 8'h00,
  parameter logic [7:0]  DIR_OFS  = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsel_i,
  input  logic              hready_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [ADDR_W-1:0] haddr_i,
  output dphase_t           dp_o
);
  logic [DEC_W-1:0] ofs;
  logic             access;
  reg_sel_e         sel_d;
  dphase_t          dp_q;
  logic             unused_hi;

  assign ofs       = haddr_i[DEC_W-1:0];
  assign unused_hi = ^{haddr_i[ADDR_W-1:DEC_W], htrans_i[0]};
  // NONSEQ and SEQ both have bit 1 set
  assign access    = hsel_i & hready_i & htrans_i[1];

  always_comb begin
    if (ofs == DEC_W'(DATA_OFS))     sel_d = SEL_DATA;
    else if (ofs == DEC_W'(DIR_OFS)) sel_d = SEL_DIR;
    else                             sel_d = SEL_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_q <= '{wr: 1'b0, rd: 1'b0, sel: SEL_NONE};
    end else begin
      dp_q.wr  <= access & hwrite_i;
      dp_q.rd  <= access & ~hwrite_i;
      dp_q.sel <= sel_d;
    end
  end

  assign dp_o = dp_q;

  AST_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hsel_i && hready_i && htrans_i[1]) |=> (!dp_o.wr && !dp_o.rd)); // R1
  AST_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dp_o.wr && dp_o.rd)); // R1
endmodule

// File: rtl/gpar_regs.sv
module gpar_regs
  import gpar_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  dphase_t           dp_i,
  input  logic [BUS_W-1:0]  hwdata_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [DATA_W-1:0] dat_o,
  output logic              dir_o,
  output logic [BUS_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] dat_q;
  logic              dir_q;
  logic              unused_wd;

  assign unused_wd = ^hwdata_i[BUS_W-1:DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= '0;
      dir_q <= 1'b0;
    end else if (dp_i.wr) begin
      case (dp_i.sel)
        SEL_DATA: dat_q <= hwdata_i[DATA_W-1:0];
        SEL_DIR:  dir_q <= hwdata_i[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (dp_i.rd) begin
      case (dp_i.sel)
        SEL_DATA: rdata_o[DATA_W-1:0] = dir_q ? dat_q : in_data_i;
        SEL_DIR:  rdata_o[0]          = dir_q;
        default:  ;
      endcase
    end
  end

  assign dat_o = dat_q;
  assign dir_o = dir_q;

  AST_DATA_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_i.wr && dp_i.sel == SEL_DATA) |=> (dat_q == $past(hwdata_i[DATA_W-1:0]))); // R2
  AST_DIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_i.wr && dp_i.sel == SEL_DIR) |=> (dir_q == $past(hwdata_i[0]))); // R3
  AST_UNMAPPED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_i.sel == SEL_NONE) |=> ($stable(dat_q) && $stable(dir_q))); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[BUS_W-1:DATA_W] == '0); // R9
endmodule

// File: rtl/gpar_in_stage.sv
module gpar_in_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W:0]   in_i,
  input  logic              sense_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  logic              exp_par;
  logic [DATA_W-1:0] data_q;
  logic              err_q;

  gpar_parity #(.DATA_W(DATA_W)) u_chk (
    .data_i  (in_i[DATA_W-1:0]),
    .sense_i (sense_i),
    .par_o   (exp_par)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      data_q <= in_i[DATA_W-1:0];
      err_q  <= in_i[DATA_W] ^ exp_par;
    end
  end

  assign data_o = data_q;
  assign err_o  = err_q;

  AST_ERR_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (err_o == (^{$past(in_i), $past(sense_i)} == 1'b0))); // R7
endmodule

// File: rtl/parity_gpio_ahb.sv
module parity_gpio_ahb
  import gpar_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int DATA_W = 16,
  parameter int DEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsel_i,
  input  logic              hready_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [BUS_W-1:0]  haddr_i,
  input  logic [BUS_W-1:0]  hwdata_i,
  input  logic [DATA_W:0]   port_in_i,
  input  logic              par_sense_i,
  output logic              hreadyout_o,
  output logic [BUS_W-1:0]  hrdata_o,
  output logic [DATA_W:0]   port_out_o,
  output logic              par_err_o
);
  dphase_t           dp;
  logic [DATA_W-1:0] in_data;
  logic [DATA_W-1:0] dat;
  logic              dir;
  logic [DATA_W-1:0] drive;
  logic              out_par;

  gpar_addr_phase #(
    .ADDR_W (BUS_W),
    .DEC_W  (DEC_W)
  ) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hsel_i   (hsel_i),
    .hready_i (hready_i),
    .htrans_i (htrans_i),
    .hwrite_i (hwrite_i),
    .haddr_i  (haddr_i),
    .dp_o     (dp)
  );

  gpar_in_stage #(.DATA_W(DATA_W)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .in_i    (port_in_i),
    .sense_i (par_sense_i),
    .data_o  (in_data),
    .err_o   (par_err_o)
  );

  gpar_regs #(
    .BUS_W  (BUS_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dp_i      (dp),
    .hwdata_i  (hwdata_i),
    .in_data_i (in_data),
    .dat_o     (dat),
    .dir_o     (dir),
    .rdata_o   (hrdata_o)
  );

  assign drive = dir ? dat : '0;

  gpar_parity #(.DATA_W(DATA_W)) u_gen (
    .data_i  (drive),
    .sense_i (par_sense_i),
    .par_o   (out_par)
  );

  assign port_out_o  = {out_par, drive};
  assign hreadyout_o = 1'b1;

  AST_OUT_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ^{port_out_o, par_sense_i} == 1'b1); // R6
  AST_IN_MODE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir |-> (port_out_o[DATA_W-1:0] == '0)); // R4
  AST_OUT_MODE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir |-> (port_out_o[DATA_W-1:0] == dat)); // R5
endmodule

// File: tb/parity_gpio_ahb_bench.sv
module parity_gpio_ahb_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hsel_i = 1'b0;
  logic        hready_i = 1'b1;
  logic [1:0]  htrans_i = 2'b00;
  logic        hwrite_i = 1'b0;
  logic [31:0] haddr_i = '0;
  logic [31:0] hwdata_i = '0;
  logic [16:0] port_in_i = '0;
  logic        par_sense_i = 1'b0;
  logic        hreadyout_o;
  logic [31:0] hrdata_o;
  logic [16:0] port_out_o;
  logic        par_err_o;

  int errors = 0;
  int checks = 0;

  // reference state
  logic [15:0] m_dat;
  logic        m_dir;
  logic [15:0] m_in;
  logic        m_err;
  logic        m_wr, m_rd;
  int          m_sel; // 0 data, 1 dir, 2 unmapped

  parity_gpio_ahb u_parity_gpio_ahb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hsel_i      (hsel_i),
    .hready_i    (hready_i),
    .htrans_i    (htrans_i),
    .hwrite_i    (hwrite_i),
    .haddr_i     (haddr_i),
    .hwdata_i    (hwdata_i),
    .port_in_i   (port_in_i),
    .par_sense_i (par_sense_i),
    .hreadyout_o (hreadyout_o),
    .hrdata_o    (hrdata_o),
    .port_out_o  (port_out_o),
    .par_err_o   (par_err_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic logic good_par(input logic [15:0] d, input logic s);
    int ones = 0;
    for (int i = 0; i < 16; i++) ones += d[i];
    ones += s;
    return (ones % 2) == 0;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_dat = '0; m_dir = 1'b0; m_in = '0; m_err = 1'b0;
    m_wr = 1'b0; m_rd = 1'b0; m_sel = 2;
  endtask

  task automatic model_step();
    if (m_wr) begin
      if (m_sel == 0) m_dat = hwdata_i[15:0];
      else if (m_sel == 1) m_dir = hwdata_i[0];
    end
    m_in  = port_in_i[15:0];
    m_err = (port_in_i[16] != good_par(port_in_i[15:0], par_sense_i));
    m_wr  = hsel_i && hready_i && (htrans_i == 2'b10 || htrans_i == 2'b11) && hwrite_i;
    m_rd  = hsel_i && hready_i && (htrans_i == 2'b10 || htrans_i == 2'b11) && !hwrite_i;
    if (haddr_i[7:0] == 8'h00) m_sel = 0;
    else if (haddr_i[7:0] == 8'h04) m_sel = 1;
    else m_sel = 2;
  endtask

  task automatic compare();
    logic [31:0] e_rd;
    logic [15:0] e_drv;
    string       t_rd;
    e_rd = '0;
    t_rd = "R1";
    if (m_rd) begin
      if (m_sel == 0) begin
        e_rd = {16'h0, m_dir ? m_dat : m_in};
        t_rd = m_dir ? "R2" : "R4";
      end else if (m_sel == 1) begin
        e_rd = {31'h0, m_dir};
        t_rd = "R3";
      end else begin
        t_rd = "R8";
      end
    end
    chk(hrdata_o === e_rd, t_rd, hrdata_o, e_rd);
    e_drv = m_dir ? m_dat : 16'h0;
    chk(port_out_o[15:0] === e_drv, m_dir ? "R5" : "R4", {16'h0, port_out_o[15:0]}, {16'h0, e_drv});
    chk(port_out_o[16] === good_par(e_drv, par_sense_i), "R6",
        {31'h0, port_out_o[16]}, {31'h0, good_par(e_drv, par_sense_i)});
    chk(par_err_o === m_err, "R7", {31'h0, par_err_o}, {31'h0, m_err});
    chk(hreadyout_o === 1'b1, "R9", {31'h0, hreadyout_o}, 32'h1);
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare();
  endtask

  task automatic set_in(input logic [15:0] d, input logic bad);
    port_in_i = {good_par(d, par_sense_i) ^ bad, d};
  endtask

  task automatic bus(input logic sel, input logic rdy, input logic [1:0] tr,
                     input logic wr, input logic [31:0] a, input logic [31:0] wd);
    hsel_i = sel; hready_i = rdy; htrans_i = tr; hwrite_i = wr; haddr_i = a;
    hwdata_i = wd;
  endtask

  // address cycle then a data cycle carrying wd
  task automatic xfer(input logic wr, input logic [31:0] a, input logic [31:0] wd);
    bus(1'b1, 1'b1, 2'b10, wr, a, $urandom);
    tick();
    bus(1'b0, 1'b1, 2'b00, 1'b0, 32'h0, wd);
    tick();
  endtask

  task automatic check_reset_state();
    chk(hrdata_o === 32'h0, "R10", hrdata_o, 32'h0);
    chk(port_out_o === {good_par(16'h0, par_sense_i), 16'h0}, "R10",
        {15'h0, port_out_o}, {15'h0, good_par(16'h0, par_sense_i), 16'h0});
    chk(par_err_o === 1'b0, "R10", {31'h0, par_err_o}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    set_in(16'h0bad, 1'b1);
    repeat (2) @(negedge clk_i);
    check_reset_state();
    rst_ni = 1'b1;

    // input mode read, R4
    set_in(16'h1234, 1'b0);
    tick();
    xfer(1'b0, 32'h0, 32'h0);
    // direction to output, read back, R3
    xfer(1'b1, 32'h4, 32'hffff_fff1);
    xfer(1'b0, 32'h4, 32'h0);
    // data write and read, R2 and R5
    xfer(1'b1, 32'h0, 32'hdead_a5c3);
    xfer(1'b0, 32'h0, 32'h0);
    // unmapped write/read, R8
    xfer(1'b1, 32'h8, 32'h0000_ffff);
    xfer(1'b0, 32'h8, 32'h0);
    xfer(1'b0, 32'h0, 32'h0);
    // non-qualifying address phases, R1
    bus(1'b0, 1'b1, 2'b10, 1'b1, 32'h0, 32'h0); tick();
    bus(1'b1, 1'b1, 2'b00, 1'b1, 32'h0, 32'h1111); tick();
    bus(1'b1, 1'b1, 2'b01, 1'b1, 32'h4, 32'h2222); tick();
    bus(1'b1, 1'b0, 2'b11, 1'b1, 32'h0, 32'h3333); tick();
    bus(1'b1, 1'b1, 2'b00, 1'b0, 32'h0, 32'h0); tick();
    xfer(1'b0, 32'h0, 32'h0);
    // sense flips and bad parity, R6 R7
    par_sense_i = 1'b1; set_in(16'h00ff, 1'b0); tick();
    set_in(16'h0f0f, 1'b1); tick();
    par_sense_i = 1'b0; tick();
    // mid-run reset, R10
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    model_reset();
    check_reset_state();
    @(negedge clk_i);
    rst_ni = 1'b1;

    // pipelined random traffic
    for (int n = 0; n < 4000; n++) begin
      int pick;
      logic [31:0] a;
      pick = $urandom_range(0, 5);
      case (pick)
        0, 1: a = 32'h0;
        2, 3: a = 32'h4;
        4:    a = 32'h100;
        default: a = {24'h0, 8'($urandom_range(8, 255))};
      endcase
      bus(($urandom_range(0, 9) != 0), ($urandom_range(0, 9) != 0),
          2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), a, $urandom);
      if ($urandom_range(0, 9) == 0) par_sense_i = ~par_sense_i;
      set_in(16'($urandom), ($urandom_range(0, 7) == 0));
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule